// File: doc/BRIEF.md
# Strobe and Dual-Acknowledge Transfer Link

This block moves words from one sender to a group of receivers that may answer at different speeds. A single strobe announces each word. Completion is signalled on shared acknowledge lines, and each of those lines is resolved as a wired-AND: a receiver that has not finished keeps its contribution low, so the line stays low. The sender acts only on rising edges of those lines. As a result it always waits for the slowest receiver, and no receiver is ever passed over.

Each word follows the same cycle. The sender presents the word and raises the strobe. Every receiver captures the word and lets go of the first acknowledge line. When the last receiver has let go, the line rises and the sender drops the strobe. Every receiver then pulls the first line low again and lets go of the second line. When the second line rises, the word is complete. Each receiver confirms that it has seen the second line high and then pulls it low. The sender does not raise a new strobe until both lines are low, so no edge is lost between words. Receiver response time is set per receiver through a latency input, which lets fast and slow receivers share the link.

A parameter selects a one-acknowledge variant. In that variant the word completes on the falling edge of the single line. Elaboration rejects it when more than one receiver is attached.

Top module: `hs3_link`

## Requirements
- R1: While reset is active and right after it, busy, done, strobe, ack1 and ack2 are 0 and every receiver's captured word is 0.
- R2: In idle, a high start sampled on a clock edge captures wdata at that edge, and busy is 1 from the next cycle. Later changes to wdata do not alter the word that is delivered.
- R3: The strobe rises only when ack1 and ack2 were both low in the cycle before, and the strobe is never high while busy is 0.
- R4: The strobe falls only on a rising edge of the resolved ack1: ack1 was high one cycle before the fall and low two cycles before.
- R5: With receiver latencies L0..Ln-1 (0 to 2^LW-1 each) and M as their maximum, done rises exactly 2*M+7 clock edges after the edge that samples start. The slowest receiver alone sets the pace.
- R6: After done, each receiver's slice of rx_data (receiver i at bits i*DW +: DW) holds the delivered word, whatever its latency.
- R7: done is high for exactly one cycle, and busy and strobe are 0 in that cycle.
- R8: ack2 rises only while the strobe is low, and it is high for a single cycle before the receivers pull it low.
- R9: A start that arrives while busy is 1 is ignored. It produces no extra done pulse and does not change the word that is delivered.
- R10: With ACK_LINES=1 and one receiver, the word completes on the falling edge of ack1, with the same 2*M+7 edge timing, and ack2 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send wdata (taken only in idle) |
| wdata | input | DW | Word to send |
| lat_cfg | input | NS*LW | Per-receiver response latency, receiver i at bits i*LW +: LW |
| busy | output | 1 | A word is in flight |
| done | output | 1 | One-cycle pulse when a word completes |
| strobe | output | 1 | Strobe line driven by the sender |
| ack1 | output | 1 | Resolved first acknowledge line |
| ack2 | output | 1 | Resolved second acknowledge line |
| rx_data | output | NS*DW | Word captured by each receiver |

## Verification
The bench builds two copies of the block. The first uses DW=16, NS=3, LW=4 and ACK_LINES=2, so three receivers with latencies anywhere from 0 to 15 cycles can be mixed in one word. This covers all receivers equal, a single slow receiver among fast ones, and the widest spread, where a fast receiver's release must not let the line rise early. The second copy uses NS=1 and ACK_LINES=1, which brings the falling-edge completion path of the one-acknowledge variant within reach and checks that its timing matches the dual-line form.

// File: rtl/hs3_pkg.sv
package hs3_pkg;
   typedef enum logic [1:0] {
      M_IDLE,
      M_ARM,
      M_HI,
      M_LO
   } mst_st_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_WAIT1,
      S_REL1,
      S_WAIT2,
      S_REL2
   } slv_st_t;
endpackage

// File: rtl/hs3_wand.sv
module hs3_wand #(
   parameter int N = 2
) (
   input  logic [N-1:0] drv,
   output logic         line
);
   // Each bit is one open-drain contributor; the line is high only when all release.
   logic [N:0] chain;
   assign chain[0] = 1'b1;
   for (genvar i = 0; i < N; i++) begin : g_and
      assign chain[i+1] = chain[i] & drv[i];
   end
   assign line = chain[N];
endmodule

// File: rtl/hs3_master.sv
module hs3_master
   import hs3_pkg::*;
#(
   parameter int DW        = 16,
   parameter int ACK_LINES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] wdata,
   input  logic          ack1,
   input  logic          ack2,
   output logic          busy,
   output logic          done,
   output logic          strobe,
   output logic [DW-1:0] bus_data
);
   mst_st_t       st;
   logic [DW-1:0] dreg;
   logic          ack1_q;
   logic          lines_idle;
   logic          finish;

   generate
      if (ACK_LINES == 2) begin : g_dual
         logic ack2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ack2_q <= 1'b0;
            else        ack2_q <= ack2;
         end
         assign lines_idle = !ack1 && !ack2;
         assign finish     = ack2 && !ack2_q;
      end else begin : g_single
         assign lines_idle = !ack1 && !ack2;
         assign finish     = !ack1 && ack1_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= M_IDLE;
         dreg   <= '0;
         ack1_q <= 1'b0;
         strobe <= 1'b0;
         done   <= 1'b0;
      end else begin
         ack1_q <= ack1;
         done   <= 1'b0;
         case (st)
            M_IDLE: if (start) begin
               dreg <= wdata;
               st   <= M_ARM;
            end
            M_ARM: if (lines_idle) begin
               strobe <= 1'b1;
               st     <= M_HI;
            end
            M_HI: if (ack1 && !ack1_q) begin
               strobe <= 1'b0;
               st     <= M_LO;
            end
            M_LO: if (finish) begin
               done <= 1'b1;
               st   <= M_IDLE;
            end
            default: st <= M_IDLE;
         endcase
      end
   end

   assign busy     = (st != M_IDLE);
   assign bus_data = dreg;
endmodule

// File: rtl/hs3_responder.sv
module hs3_responder
   import hs3_pkg::*;
#(
   parameter int DW        = 16,
   parameter int LW        = 4,
   parameter int ACK_LINES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] lat,
   input  logic          strobe,
   input  logic [DW-1:0] bus_data,
   input  logic          ack2_line,
   output logic          rel1,
   output logic          rel2,
   output logic [DW-1:0] rx
);
   localparam bit DUAL = (ACK_LINES == 2);

   slv_st_t       st;
   logic [LW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         cnt  <= '0;
         rel1 <= 1'b0;
         rel2 <= 1'b0;
         rx   <= '0;
      end else begin
         case (st)
            S_IDLE: if (strobe) begin
               st  <= S_WAIT1;
               cnt <= '0;
            end
            S_WAIT1: if (cnt == lat) begin
               rel1 <= 1'b1;
               rx   <= bus_data;
               st   <= S_REL1;
            end else begin
               cnt <= cnt + 1'b1;
            end
            S_REL1: if (!strobe) begin
               st  <= S_WAIT2;
               cnt <= '0;
            end
            S_WAIT2: if (cnt == lat) begin
               rel1 <= 1'b0;
               if (DUAL) begin
                  rel2 <= 1'b1;
                  st   <= S_REL2;
               end else begin
                  st <= S_IDLE;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
            S_REL2: if (ack2_line) begin
               rel2 <= 1'b0;
               st   <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hs3_link.sv
module hs3_link #(
   parameter int DW        = 16,
   parameter int NS        = 3,
   parameter int LW        = 4,
   parameter int ACK_LINES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DW-1:0]    wdata,
   input  logic [NS*LW-1:0] lat_cfg,
   output logic             busy,
   output logic             done,
   output logic             strobe,
   output logic             ack1,
   output logic             ack2,
   output logic [NS*DW-1:0] rx_data
);
   generate
      if (ACK_LINES != 1 && ACK_LINES != 2) begin : g_bad_lines
         $error("hs3_link: ACK_LINES must be 1 or 2");
      end
      if (ACK_LINES == 1 && NS > 1) begin : g_bad_single
         $error("hs3_link: one acknowledge line cannot serve several receivers");
      end
      if (NS < 1 || DW < 1 || LW < 1) begin : g_bad_size
         $error("hs3_link: NS, DW and LW must be positive");
      end
   endgenerate

   logic [DW-1:0] bus_data;
   logic [NS-1:0] rel1_v;
   logic [NS-1:0] rel2_v;

   hs3_master #(.DW(DW), .ACK_LINES(ACK_LINES)) u_master (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .wdata    (wdata),
      .ack1     (ack1),
      .ack2     (ack2),
      .busy     (busy),
      .done     (done),
      .strobe   (strobe),
      .bus_data (bus_data)
   );

   for (genvar i = 0; i < NS; i++) begin : g_rx
      hs3_responder #(.DW(DW), .LW(LW), .ACK_LINES(ACK_LINES)) u_resp (
         .clk       (clk),
         .rst_n     (rst_n),
         .lat       (lat_cfg[i*LW +: LW]),
         .strobe    (strobe),
         .bus_data  (bus_data),
         .ack2_line (ack2),
         .rel1      (rel1_v[i]),
         .rel2      (rel2_v[i]),
         .rx        (rx_data[i*DW +: DW])
      );
   end

   hs3_wand #(.N(NS)) u_ack1 (.drv(rel1_v), .line(ack1));
   hs3_wand #(.N(NS)) u_ack2 (.drv(rel2_v), .line(ack2));
endmodule

// File: rtl/hs3_link_chk.sv
module hs3_link_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic strobe,
   input logic ack1,
   input logic ack2
);
   AST_STB_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> $past(!ack1 && !ack2)); // R3
   AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !strobe); // R3
   AST_STB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe) |-> ($past(ack1) && !$past(ack1, 2))); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !strobe)); // R7
   AST_ACK2_LOW_STB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack2) |-> !strobe); // R8
   AST_ACK2_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      ack2 |=> !ack2); // R8
endmodule

bind hs3_link hs3_link_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .strobe (strobe),
   .ack1   (ack1),
   .ack2   (ack2)
);

// File: tb/hs3_link_bench.sv
module hs3_link_bench;
   localparam int DW = 16;
   localparam int NS = 3;
   localparam int LW = 4;
   localparam int VW = NS*LW + DW;
   localparam int NV = 6;

   // entry = {lat2, lat1, lat0, word}
   localparam logic [VW-1:0] VEC [NV] = '{
      {4'd0,  4'd0,  4'd0,  16'h1234},
      {4'd5,  4'd0,  4'd0,  16'hA5A5},
      {4'd0,  4'd9,  4'd2,  16'h0FF0},
      {4'd15, 4'd15, 4'd15, 16'hFFFF},
      {4'd1,  4'd7,  4'd3,  16'h0001},
      {4'd0,  4'd15, 4'd0,  16'h8000}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_n;
   logic             start;
   logic [DW-1:0]    wdata;
   logic [NS*LW-1:0] lat_cfg;
   logic             busy, done, strobe, ack1, ack2;
   logic [NS*DW-1:0] rx_data;

   logic             b_start;
   logic [DW-1:0]    b_wdata;
   logic [LW-1:0]    b_lat;
   logic             b_busy, b_done, b_strobe, b_ack1, b_ack2;
   logic [DW-1:0]    b_rx;

   hs3_link #(.DW(DW), .NS(NS), .LW(LW), .ACK_LINES(2)) u_hs3_link (
      .clk(clk), .rst_n(rst_n), .start(start), .wdata(wdata), .lat_cfg(lat_cfg),
      .busy(busy), .done(done), .strobe(strobe), .ack1(ack1), .ack2(ack2),
      .rx_data(rx_data));

   hs3_link #(.DW(DW), .NS(1), .LW(LW), .ACK_LINES(1)) u_hs3_link_1ack (
      .clk(clk), .rst_n(rst_n), .start(b_start), .wdata(b_wdata), .lat_cfg(b_lat),
      .busy(b_busy), .done(b_done), .strobe(b_strobe), .ack1(b_ack1), .ack2(b_ack2),
      .rx_data(b_rx));

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // line monitor sampled at negedges
   int r3_bad = 0, r4_bad = 0, r8_bad = 0, b_ack2_seen = 0;
   logic p_stb = 1'b0, p_a1 = 1'b0, pp_a1 = 1'b0, p_a2 = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (strobe && !p_stb && (p_a1 || p_a2)) r3_bad++;
         if (strobe && !busy) r3_bad++;
         if (!strobe && p_stb && !(p_a1 && !pp_a1)) r4_bad++;
         if (ack2 && !p_a2 && strobe) r8_bad++;
         if (ack2 && p_a2) r8_bad++;
         if (b_ack2) b_ack2_seen++;
      end
      pp_a1 = p_a1;
      p_a1  = ack1;
      p_a2  = ack2;
      p_stb = strobe;
   end

   // returns number of negedges from start drive until done is seen
   task automatic send(input logic [DW-1:0] d, input logic [NS*LW-1:0] lats,
                       output int cyc);
      @(negedge clk);
      wdata = d; lat_cfg = lats; start = 1'b1; cyc = 0;
      @(negedge clk);
      cyc = 1; start = 1'b0; wdata = ~d;
      chk(busy == 1'b1, "R2", "busy after start", busy, 1);
      while (!done && cyc < 300) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   int watchdog_hit = 0;
   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; wdata = '0; lat_cfg = '0;
      b_start = 1'b0; b_wdata = '0; b_lat = '0;
      repeat (3) @(negedge clk);
      chk({busy, done, strobe, ack1, ack2} == 5'b0, "R1", "outputs in reset",
          {busy, done, strobe, ack1, ack2}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, strobe, ack1, ack2} == 5'b0, "R1", "outputs after reset",
          {busy, done, strobe, ack1, ack2}, 0);
      chk(rx_data == '0, "R1", "captured words", rx_data, 0);

      // table walk: R5 timing, R6 capture, R7 pulse shape, R2 capture timing
      for (int v = 0; v < NV; v++) begin
         logic [DW-1:0]    w;
         logic [NS*LW-1:0] l;
         int m, cyc;
         w = VEC[v][DW-1:0];
         l = VEC[v][VW-1:DW];
         m = 0;
         for (int i = 0; i < NS; i++)
            if (int'(l[i*LW +: LW]) > m) m = int'(l[i*LW +: LW]);
         send(w, l, cyc);
         chk(cyc == 2*m + 8, "R5", "cycles to done", cyc, 2*m + 8);
         chk(!busy && !strobe, "R7", "busy/strobe with done", {busy, strobe}, 0);
         for (int i = 0; i < NS; i++)
            chk(rx_data[i*DW +: DW] == w, "R6", "receiver word",
                rx_data[i*DW +: DW], w);
         @(negedge clk);
         chk(done == 1'b0, "R7", "done width", done, 0);
      end

      // R2: word captured at the start edge even though wdata changed afterwards
      begin
         int cyc;
         send(16'h3C3C, {4'd2, 4'd4, 4'd1}, cyc);
         chk(rx_data[DW +: DW] == 16'h3C3C, "R2", "word after wdata change",
             rx_data[DW +: DW], 16'h3C3C);
      end

      // R9: start while busy is ignored
      begin
         int dones;
         @(negedge clk);
         wdata = 16'h5151; lat_cfg = {4'd3, 4'd3, 4'd3}; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (3) @(negedge clk);
         wdata = 16'h7E7E; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         dones = 0;
         repeat (40) begin
            @(negedge clk);
            if (done) dones++;
         end
         chk(dones == 1, "R9", "done pulses", dones, 1);
         chk(rx_data[2*DW +: DW] == 16'h5151, "R9", "delivered word",
             rx_data[2*DW +: DW], 16'h5151);
         chk(busy == 1'b0, "R9", "no second transfer", busy, 0);
      end

      // R10: single acknowledge line, one receiver
      begin
         int cyc;
         @(negedge clk);
         b_wdata = 16'hBEEF; b_lat = 4'd6; b_start = 1'b1;
         @(negedge clk);
         cyc = 1; b_start = 1'b0;
         while (!b_done && cyc < 300) begin
            @(negedge clk);
            cyc++;
         end
         chk(cyc == 2*6 + 8, "R10", "single-line cycles", cyc, 20);
         chk(b_rx == 16'hBEEF, "R10", "single-line word", b_rx, 16'hBEEF);
         chk(b_ack2_seen == 0, "R10", "ack2 stays low", b_ack2_seen, 0);
      end

      chk(r3_bad == 0, "R3", "strobe raise violations", r3_bad, 0);
      chk(r4_bad == 0, "R4", "strobe drop violations", r4_bad, 0);
      chk(r8_bad == 0, "R8", "ack2 rise violations", r8_bad, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule